// File: doc/BRIEF.md
# Double-Buffered Frame Destination Address Selector

This block keeps the destination base addresses for pixel data arriving on four logical channels of a camera receiver. Each channel has two programmable base addresses, called ping and pong, and software can write them at any time through a single-cycle memory-mapped register port. What software writes is held in a programming register. The copy used for addressing (the shadow) picks up those values only when the channel's own frame-start pulse arrives.

On every frame start the channel reloads its shadows and decides which buffer the new frame uses. Alternation between ping and pong happens only when the two loaded addresses differ. When they are equal, every frame goes to the same address. The block drives the active base address for each channel, aligned to 32 bytes, and a flag that says whether the frame uses pong. A downstream DMA engine consumes both outputs.

Top module: `ppaddr_top`

## Requirements
- R1: Channel c (0..3) has its ping register at byte offset 0x70 + 0x30*c and its pong register at 0x74 + 0x30*c. A write to either register reads back the written value with bits 4:0 cleared.
- R2: Bits 4:0 are zero at all times in read data and in every base address output.
- R3: After reset, every register reads zero, every base address output is zero and every buffer flag is 0 (ping).
- R4: Reads of unmapped offsets, including unaligned ones inside a group, return zero. Writes to unmapped offsets change no register and no output.
- R5: A channel's base address and buffer flag stay unchanged in every cycle that has no frame-start pulse on that channel. Register writes and frame starts on other channels do not change them.
- R6: A frame-start pulse on a channel copies that channel's programmed ping and pong values into its shadows. The new base address appears in the next cycle. The first frame after reset uses ping.
- R7: When the loaded ping and pong differ (compared on bits 31:5), every frame start after the first flips the buffer flag. The output address is pong when the flag is 1 and ping when it is 0.
- R8: When the loaded ping and pong are equal, a frame start sets the buffer flag to 0.
- R9: Reads return the programmed value, not the shadow value in use.
- R10: A write in the same cycle as that channel's frame-start pulse is not loaded by that pulse. It is loaded by the following frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Write strobe for regAddr |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, same cycle |
| frameStart | input | 4 | One-cycle frame-start pulse per channel |
| baseAddr | output | 128 | Active base address; channel c in bits 32c+31:32c |
| bufSel | output | 4 | Per channel: 1 when the current frame uses pong |

## Verification
A wrong selection bit or a stale shadow shows on baseAddr and bufSel one cycle after the frame-start pulse that exposes it. The scoreboard compares every channel pulsed in each frame event, so an error appears no later than the first frame after the bad state arises. A lost or leaked write shows immediately on readback, because reads are combinational. A shadow that loads too early shows as an output change in a cycle with no pulse, and both the bench and a stability property watch for that.

// File: rtl/ppaddr_pkg.sv
package ppaddr_pkg;
  localparam int PP_NUM_CH = 4;

  typedef struct packed {
    logic [PP_NUM_CH-1:0] wrPing;
    logic [PP_NUM_CH-1:0] wrPong;
    logic [PP_NUM_CH-1:0] rdPing;
    logic [PP_NUM_CH-1:0] rdPong;
    logic [PP_NUM_CH-1:0] load;
  } ppStrobe_t;
endpackage

// File: rtl/ppaddr_ctrl.sv
// Address decode and per-channel buffer selection state.
module ppaddr_ctrl
  import ppaddr_pkg::*;
#(
  parameter int REG_AW   = 12,
  parameter int BASE_OFF = 'h70,
  parameter int PONG_OFF = 4,
  parameter int STRIDE   = 'h30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [PP_NUM_CH-1:0] frameStart,
  input  logic [PP_NUM_CH-1:0] progDiff,
  output ppStrobe_t            strobe,
  output logic [PP_NUM_CH-1:0] selPong
);
  logic [PP_NUM_CH-1:0] started;
  logic [PP_NUM_CH-1:0] pingHit;
  logic [PP_NUM_CH-1:0] pongHit;

  for (genvar c = 0; c < PP_NUM_CH; c++) begin : g_ch
    localparam logic [REG_AW-1:0] PING_A = REG_AW'(BASE_OFF + c * STRIDE);
    localparam logic [REG_AW-1:0] PONG_A = REG_AW'(BASE_OFF + c * STRIDE + PONG_OFF);

    assign pingHit[c] = (regAddr == PING_A);
    assign pongHit[c] = (regAddr == PONG_A);

    // The first frame uses ping. After that the flag flips only while the
    // loaded pair differs; an equal pair forces ping.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        started[c] <= 1'b0;
        selPong[c] <= 1'b0;
      end else if (frameStart[c]) begin
        started[c] <= 1'b1;
        if (!started[c] || !progDiff[c]) selPong[c] <= 1'b0;
        else                             selPong[c] <= ~selPong[c];
      end
    end
  end

  always_comb begin
    strobe.rdPing = pingHit;
    strobe.rdPong = pongHit;
    strobe.wrPing = regWrEn ? pingHit : '0;
    strobe.wrPong = regWrEn ? pongHit : '0;
    strobe.load   = frameStart;
  end
endmodule

// File: rtl/ppaddr_datapath.sv
// Programming registers, shadow copies, read mux and base address output.
module ppaddr_datapath
  import ppaddr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ppStrobe_t                     strobe,
  input  logic [ADDR_W-ALIGN_BITS-1:0]  wrHigh,
  input  logic [PP_NUM_CH-1:0]          selPong,
  output logic [PP_NUM_CH-1:0]          progDiff,
  output logic [ADDR_W-1:0]             rdData,
  output logic [PP_NUM_CH*ADDR_W-1:0]   baseAddr
);
  localparam int HI_W = ADDR_W - ALIGN_BITS;

  logic [HI_W-1:0] progPing [PP_NUM_CH];
  logic [HI_W-1:0] progPong [PP_NUM_CH];
  logic [HI_W-1:0] shPing   [PP_NUM_CH];
  logic [HI_W-1:0] shPong   [PP_NUM_CH];

  for (genvar c = 0; c < PP_NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        progPing[c] <= '0;
        progPong[c] <= '0;
      end else begin
        if (strobe.wrPing[c]) progPing[c] <= wrHigh;
        if (strobe.wrPong[c]) progPong[c] <= wrHigh;
      end
    end

    // Shadows take the values held before any write in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shPing[c] <= '0;
        shPong[c] <= '0;
      end else if (strobe.load[c]) begin
        shPing[c] <= progPing[c];
        shPong[c] <= progPong[c];
      end
    end

    assign progDiff[c] = (progPing[c] != progPong[c]);
    assign baseAddr[c*ADDR_W +: ADDR_W] =
      {(selPong[c] ? shPong[c] : shPing[c]), {ALIGN_BITS{1'b0}}};
  end

  always_comb begin
    logic [HI_W-1:0] acc;
    acc = '0;
    for (int c = 0; c < PP_NUM_CH; c++) begin
      if (strobe.rdPing[c]) acc = acc | progPing[c];
      if (strobe.rdPong[c]) acc = acc | progPong[c];
    end
    rdData = {acc, {ALIGN_BITS{1'b0}}};
  end
endmodule

// File: rtl/ppaddr_top.sv
module ppaddr_top
  import ppaddr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 5,
  parameter int REG_AW     = 12,
  parameter int BASE_OFF   = 'h70,
  parameter int PONG_OFF   = 4,
  parameter int STRIDE     = 'h30
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [REG_AW-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [ADDR_W-1:0]           regWrData,
  output logic [ADDR_W-1:0]           regRdData,
  input  logic [PP_NUM_CH-1:0]        frameStart,
  output logic [PP_NUM_CH*ADDR_W-1:0] baseAddr,
  output logic [PP_NUM_CH-1:0]        bufSel
);
  ppStrobe_t            strobe;
  logic [PP_NUM_CH-1:0] progDiff;
  logic [PP_NUM_CH-1:0] selPong;

  ppaddr_ctrl #(
    .REG_AW(REG_AW), .BASE_OFF(BASE_OFF), .PONG_OFF(PONG_OFF), .STRIDE(STRIDE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .frameStart(frameStart), .progDiff(progDiff), .strobe(strobe),
    .selPong(selPong)
  );

  ppaddr_datapath #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrHigh(regWrData[ADDR_W-1:ALIGN_BITS]), .selPong(selPong),
    .progDiff(progDiff), .rdData(regRdData), .baseAddr(baseAddr)
  );

  assign bufSel = selPong;
endmodule

// File: rtl/ppaddr_checker.sv
module ppaddr_checker
  import ppaddr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [ADDR_W-1:0]           regRdData,
  input logic [PP_NUM_CH-1:0]        frameStart,
  input logic [PP_NUM_CH*ADDR_W-1:0] baseAddr,
  input logic [PP_NUM_CH-1:0]        bufSel,
  input logic [PP_NUM_CH-1:0]        progDiff
);
  p_rd_low_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[ALIGN_BITS-1:0] == '0);

  for (genvar c = 0; c < PP_NUM_CH; c++) begin : g_ch
    p_base_low_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
      baseAddr[c*ADDR_W +: ALIGN_BITS] == '0);

    p_hold_without_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
      !frameStart[c] |=> ($stable(baseAddr[c*ADDR_W +: ADDR_W]) && $stable(bufSel[c])));

    p_equal_pair_ping_r8: assert property (@(posedge clk) disable iff (!rstN)
      (frameStart[c] && !progDiff[c]) |=> !bufSel[c]);
  end
endmodule

bind ppaddr_top ppaddr_checker #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .frameStart(frameStart),
  .baseAddr(baseAddr), .bufSel(bufSel), .progDiff(progDiff)
);

// File: tb/ppaddr_top_tb_top.sv
`timescale 1ns/1ps
module ppaddr_top_tb_top;
  localparam int NCH = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [11:0]      regAddr = '0;
  logic             regWrEn = 1'b0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic [NCH-1:0]   frameStart = '0;
  logic [NCH*32-1:0] baseAddr;
  logic [NCH-1:0]   bufSel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ppaddr_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .frameStart(frameStart),
    .baseAddr(baseAddr), .bufSel(bufSel)
  );

  // Reference model, built from the requirements.
  logic [31:0] mPing [NCH];
  logic [31:0] mPong [NCH];
  logic        mSel  [NCH];
  bit          mStarted [NCH];

  typedef struct {
    int          ch;
    logic [31:0] base;
    logic        sel;
    string       req;
  } item_t;
  item_t expQ[$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pingOff(int c);
    return 12'(12'h070 + c * 12'h030);
  endfunction

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (a == pingOff(c))     mPing[c] = {d[31:5], 5'b0};
      if (a == pingOff(c) + 4) mPong[c] = {d[31:5], 5'b0};
    end
  endtask

  task automatic regRead(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData === exp, req, regRdData, exp);
  endtask

  // Apply the model for one channel's frame start and queue the expectation.
  task automatic modelFrame(int c, string req);
    item_t it;
    if (!mStarted[c] || mPing[c] == mPong[c]) mSel[c] = 1'b0;
    else                                       mSel[c] = ~mSel[c];
    mStarted[c] = 1'b1;
    it.ch = c; it.sel = mSel[c]; it.req = req;
    it.base = mSel[c] ? mPong[c] : mPing[c];
    expQ.push_back(it);
  endtask

  // Driver: pulse frame start on the masked channels, optionally with a write.
  task automatic frame(logic [NCH-1:0] mask, string req,
                       bit doWr = 0, logic [11:0] a = '0, logic [31:0] d = '0);
    @(negedge clk);
    frameStart = mask;
    if (doWr) begin regAddr = a; regWrEn = 1'b1; regWrData = d; end
    @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) if (mask[c]) modelFrame(c, req);
    if (doWr)
      for (int c = 0; c < NCH; c++) begin
        if (a == pingOff(c))     mPing[c] = {d[31:5], 5'b0};
        if (a == pingOff(c) + 4) mPong[c] = {d[31:5], 5'b0};
      end
    @(negedge clk);
    frameStart = '0; regWrEn = 1'b0;
  endtask

  // Monitor: compare queued expectations one cycle after the pulse.
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      check(baseAddr[it.ch*32 +: 32] === it.base, it.req,
            baseAddr[it.ch*32 +: 32], it.base);
      check(bufSel[it.ch] === it.sel, it.req, 32'(bufSel[it.ch]), 32'(it.sel));
    end
  end

  task automatic checkOutputs(string req);
    @(negedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin
      logic [31:0] e;
      e = mSel[c] ? mPong[c] : mPing[c];
      if (!mStarted[c]) e = 32'h0;
      check(baseAddr[c*32 +: 32] === e, req, baseAddr[c*32 +: 32], e);
    end
  endtask

  logic [31:0] holdBase [NCH];

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mPing[c] = '0; mPong[c] = '0; mSel[c] = 1'b0; mStarted[c] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3: reset values
    for (int c = 0; c < NCH; c++) begin
      regRead(pingOff(c), 32'h0, "R3 ping reset");
      regRead(pingOff(c) + 4, 32'h0, "R3 pong reset");
    end
    check(baseAddr === '0, "R3 base reset", baseAddr[31:0], 32'h0);
    check(bufSel === '0, "R3 sel reset", 32'(bufSel), 32'h0);

    // R1 / R2: map and low-bit masking
    regWrite(pingOff(0), 32'h1000_001F);
    regWrite(pingOff(0) + 4, 32'h2000_0007);
    regRead(pingOff(0), 32'h1000_0000, "R1 R2 ping readback");
    regRead(pingOff(0) + 4, 32'h2000_0000, "R1 R2 pong readback");
    regWrite(pingOff(3) + 4, 32'hCAFE_BEEF);
    regRead(pingOff(3) + 4, 32'hCAFE_BEE0, "R1 ch3 pong readback");

    // R5 / R9: writes not yet in use; reads show programmed value
    checkOutputs("R5 no frame yet");
    regRead(pingOff(0), 32'h1000_0000, "R9 read programmed");

    // R6 / R7: first frame ping, then alternate
    frame(4'b0001, "R6 first frame ping");
    frame(4'b0001, "R7 second frame pong");
    frame(4'b0001, "R7 third frame ping");
    frame(4'b0001, "R7 fourth frame pong");

    // R8: equal pair stays on ping
    regWrite(pingOff(1), 32'h3000_0040);
    regWrite(pingOff(1) + 4, 32'h3000_005F);
    frame(4'b0010, "R8 equal first");
    frame(4'b0010, "R8 equal second");
    frame(4'b0010, "R8 equal third");

    // R8 on ch0: pair made equal while on pong forces ping
    regWrite(pingOff(0) + 4, 32'h1000_0000);
    frame(4'b0001, "R8 equalized pair");

    // R4: unmapped offsets
    for (int c = 0; c < NCH; c++) holdBase[c] = baseAddr[c*32 +: 32];
    regWrite(12'h06C, 32'hFFFF_FFFF);
    regWrite(12'h078, 32'hFFFF_FFFF);
    regWrite(12'h071, 32'hFFFF_FFFF);
    regRead(12'h06C, 32'h0, "R4 read below map");
    regRead(12'h071, 32'h0, "R4 unaligned read");
    regRead(12'h160, 32'h0, "R4 read past map");
    regRead(pingOff(0), 32'h1000_0000, "R4 ping untouched");
    regRead(pingOff(1), 32'h3000_0040, "R4 ch1 ping untouched");
    regRead(pingOff(2), 32'h0, "R4 ch2 ping untouched");
    for (int c = 0; c < NCH; c++)
      check(baseAddr[c*32 +: 32] === holdBase[c], "R4 R5 outputs unchanged",
            baseAddr[c*32 +: 32], holdBase[c]);

    // R10: write coincident with frame start is deferred
    regWrite(pingOff(2), 32'h4000_0000);
    frame(4'b0100, "R10 setup ping A");
    frame(4'b0100, "R10 coincident write not loaded", 1, pingOff(2), 32'h5000_0000);
    frame(4'b0100, "R10 loaded at next frame");

    // R5: frames on other channels leave ch3 alone, then all at once
    regWrite(pingOff(3), 32'h6000_0020);
    frame(4'b0011, "R5 other channels");
    checkOutputs("R5 ch3 unchanged");
    frame(4'b1111, "R7 all channels");
    frame(4'b1111, "R7 all channels again");
    checkOutputs("R2 R6 outputs consistent");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule